// File: doc/BRIEF.md
# Reset and Power-Up Sequencer

This block brings an audio PWM processor out of reset in a fixed order. An active-low reset pin forces the block into its reset state at once, without waiting for a clock edge. In that state the PWM outputs are held low, the PWM stage is in hard mute, the volume target is full attenuation (with no ramp), and control-bus and serial-audio traffic is refused. Reset release is synchronised to the free-running reference clock.

Once reset is released and the power enable is high, the sequencer waits for the master clock to be running. It then starts a timed initialization window, measured in master-clock rising edges, and pulses a load-defaults command to the control registers as it enters that window. If the master clock stops during the window, the sequencer goes back to waiting and restarts the window later. At the end of the window it releases mute, moves the volume target to 0 dB and pulses a ramp-start command to the volume unit. When the volume unit reports that the ramp is done, the sequencer reports ready.

A watchdog on the reference clock judges master-clock activity. The clock counts as active from its first sampled rising edge. It counts as inactive once a programmable number of reference cycles passes with no rising edge.

Top module: `bringup_seq`

## Requirements
- R1: When rstPinN goes low, hardMute, pwmForceLow, volFullAtten and accessBlock all go to 1 and seqReady goes to 0 without any clock edge.
- R2: accessBlock is 1 exactly while the sequencer is in its reset state. That covers rstPinN low, the synchroniser delay, and any time powerEn stays low after release. Whenever accessBlock is 1, hardMute is also 1.
- R3: After reset release with powerEn low, the sequencer stays in its reset state. With powerEn high, it leaves that state and accessBlock drops to 0.
- R4: mclkActive becomes 1 after a sampled rising edge on mclkIn. It becomes 0 once WDOG_CYCLES reference cycles pass with no rising edge.
- R5: loadDefaults is never issued while the master clock is inactive. With mclkIn stopped after release, no loadDefaults pulse occurs and mute stays on.
- R6: loadDefaults is a single-cycle pulse, issued once on each entry into the initialization window.
- R7: The initialization window lasts INIT_EDGES master-clock rising edges, within one edge. Defaults give about 4.5 ms at 24.576 MHz.
- R8: If the master clock goes inactive during initialization, mute and attenuation stay on. When the clock returns, initialization restarts with a fresh loadDefaults pulse.
- R9: At the end of initialization, rampStart pulses for one cycle. In that same cycle hardMute, pwmForceLow and volFullAtten drop to 0.
- R10: seqReady rises only after rampDone is seen while ramping. rampDone has no effect in any earlier state.
- R11: Once ready, loss of the master clock leaves hardMute, volFullAtten and seqReady unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstPinN | input | 1 | Asynchronous active-low reset pin |
| powerEn | input | 1 | High allows bring-up after reset release |
| mclkIn | input | 1 | Master clock, sampled as data |
| rampDone | input | 1 | Volume unit reports the soft ramp has finished |
| hardMute | output | 1 | Hard-mute command to the PWM stage |
| pwmForceLow | output | 1 | Forces all PWM outputs low |
| volFullAtten | output | 1 | Volume target: 1 = full attenuation, 0 = 0 dB |
| accessBlock | output | 1 | Control-bus and serial-audio operations refused |
| loadDefaults | output | 1 | One-cycle command to restore control defaults |
| rampStart | output | 1 | One-cycle command to start the soft ramp up |
| seqReady | output | 1 | Bring-up complete |
| mclkActive | output | 1 | Master-clock watchdog verdict |

## Verification
A table of input combinations is applied after a fresh reset each time, and the outputs are checked once things have settled:
- Power enable low versus high separates holding in reset from moving on.
- Master clock stopped versus running separates waiting from initializing.
- A ramp-done input that is early or held separates ramping from ready, and shows that ramp-done is ignored before the ramp.

Directed runs then check the following:
- The reset pin is dropped between clock edges to show the outputs follow it at once.
- The window length is measured in master-clock edges.
- The master clock is stopped in the middle of initialization to show the restart and the second defaults pulse.
- The master clock is stopped once ready to show the watchdog verdict changes while the audio state does not.

// File: rtl/bringup_pkg.sv
package bringup_pkg;
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_WAIT_CLK = 3'd1,
    ST_INIT     = 3'd2,
    ST_RAMP     = 3'd3,
    ST_RUN      = 3'd4
  } seqState_e;

  typedef struct packed {
    logic clrInit;
    logic cntEn;
  } seqStrobe_t;
endpackage

// File: rtl/bringup_rst_sync.sv
module bringup_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstPinN,
  output logic rstSyncN
);
  logic [SYNC_STAGES-1:0] shiftQ;

  // assert asynchronously, release on the reference clock
  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) shiftQ <= '0;
    else          shiftQ <= {shiftQ[SYNC_STAGES-2:0], 1'b1};
  end

  assign rstSyncN = shiftQ[SYNC_STAGES-1];
endmodule

// File: rtl/bringup_dp.sv
module bringup_dp import bringup_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int WDOG_CYCLES = 64,
  parameter int INIT_EDGES  = 110592
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mclkIn,
  input  seqStrobe_t strobe,
  output logic       mclkActive,
  output logic       initDone
);
  localparam int WW = (WDOG_CYCLES > 1) ? $clog2(WDOG_CYCLES) : 1;
  localparam int IW = $clog2(INIT_EDGES + 1);
  localparam logic [WW-1:0] WD_LAST   = WW'(WDOG_CYCLES - 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_EDGES);

  logic [SYNC_STAGES-1:0] mclkSync;
  logic                   mclkPrev;
  logic                   mclkEdge;
  logic [WW-1:0]          wdogCnt;
  logic [IW-1:0]          initCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mclkSync <= '0;
      mclkPrev <= 1'b0;
    end else begin
      mclkSync <= {mclkSync[SYNC_STAGES-2:0], mclkIn};
      mclkPrev <= mclkSync[SYNC_STAGES-1];
    end
  end

  assign mclkEdge = mclkSync[SYNC_STAGES-1] & ~mclkPrev;

  // activity watchdog on the reference clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdogCnt    <= '0;
      mclkActive <= 1'b0;
    end else if (mclkEdge) begin
      wdogCnt    <= '0;
      mclkActive <= 1'b1;
    end else if (wdogCnt == WD_LAST) begin
      mclkActive <= 1'b0;
    end else begin
      wdogCnt <= wdogCnt + 1'b1;
    end
  end

  // initialization window, counted in master-clock edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          initCnt <= '0;
    else if (strobe.clrInit)                            initCnt <= '0;
    else if (strobe.cntEn && mclkEdge && !initDone)     initCnt <= initCnt + 1'b1;
  end

  assign initDone = (initCnt == INIT_LAST);
endmodule

// File: rtl/bringup_ctrl.sv
module bringup_ctrl import bringup_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerEn,
  input  logic       mclkActive,
  input  logic       initDone,
  input  logic       rampDone,
  output seqStrobe_t strobe,
  output logic       loadDefaults,
  output logic       rampStart,
  output logic       hardMute,
  output logic       pwmForceLow,
  output logic       volFullAtten,
  output logic       accessBlock,
  output logic       seqReady
);
  seqState_e stateQ, stateD;
  logic      enterInit, enterRamp;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RESET:    if (powerEn)    stateD = ST_WAIT_CLK;
      ST_WAIT_CLK: if (mclkActive) stateD = ST_INIT;
      ST_INIT: begin
        if (!mclkActive)   stateD = ST_WAIT_CLK;
        else if (initDone) stateD = ST_RAMP;
      end
      ST_RAMP:     if (rampDone)   stateD = ST_RUN;
      ST_RUN:                      stateD = ST_RUN;
      default:                     stateD = ST_RESET;
    endcase
  end

  assign enterInit = (stateD == ST_INIT) && (stateQ != ST_INIT);
  assign enterRamp = (stateD == ST_RAMP) && (stateQ != ST_RAMP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ       <= ST_RESET;
      loadDefaults <= 1'b0;
      rampStart    <= 1'b0;
    end else begin
      stateQ       <= stateD;
      loadDefaults <= enterInit;
      rampStart    <= enterRamp;
    end
  end

  assign strobe.clrInit = enterInit;
  assign strobe.cntEn   = (stateQ == ST_INIT);

  always_comb begin
    hardMute     = (stateQ == ST_RESET) || (stateQ == ST_WAIT_CLK) || (stateQ == ST_INIT);
    pwmForceLow  = hardMute;
    volFullAtten = hardMute;
    accessBlock  = (stateQ == ST_RESET);
    seqReady     = (stateQ == ST_RUN);
  end
endmodule

// File: rtl/bringup_seq.sv
module bringup_seq import bringup_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int WDOG_CYCLES = 64,
  parameter int INIT_EDGES  = 110592
) (
  input  logic clk,
  input  logic rstPinN,
  input  logic powerEn,
  input  logic mclkIn,
  input  logic rampDone,
  output logic hardMute,
  output logic pwmForceLow,
  output logic volFullAtten,
  output logic accessBlock,
  output logic loadDefaults,
  output logic rampStart,
  output logic seqReady,
  output logic mclkActive
);
  logic       rstSyncN;
  logic       initDone;
  seqStrobe_t strobe;

  bringup_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) uRst (
    .clk(clk), .rstPinN(rstPinN), .rstSyncN(rstSyncN)
  );

  bringup_dp #(
    .SYNC_STAGES(SYNC_STAGES), .WDOG_CYCLES(WDOG_CYCLES), .INIT_EDGES(INIT_EDGES)
  ) uDp (
    .clk(clk), .rstN(rstSyncN), .mclkIn(mclkIn), .strobe(strobe),
    .mclkActive(mclkActive), .initDone(initDone)
  );

  bringup_ctrl uCtrl (
    .clk(clk), .rstN(rstSyncN), .powerEn(powerEn), .mclkActive(mclkActive),
    .initDone(initDone), .rampDone(rampDone), .strobe(strobe),
    .loadDefaults(loadDefaults), .rampStart(rampStart), .hardMute(hardMute),
    .pwmForceLow(pwmForceLow), .volFullAtten(volFullAtten),
    .accessBlock(accessBlock), .seqReady(seqReady)
  );
endmodule

// File: rtl/bringup_seq_chk.sv
module bringup_seq_chk (
  input logic clk,
  input logic rstPinN,
  input logic rampDone,
  input logic hardMute,
  input logic pwmForceLow,
  input logic volFullAtten,
  input logic accessBlock,
  input logic loadDefaults,
  input logic rampStart,
  input logic seqReady,
  input logic mclkActive
);
  always @(posedge clk) begin
    if (!rstPinN) begin
      AST_RST_FORCES_SAFE: assert (hardMute && pwmForceLow && volFullAtten && accessBlock && !seqReady); // R1
    end
  end

  AST_BLOCK_IMPLIES_MUTE: assert property (@(posedge clk) disable iff (!rstPinN)
    accessBlock |-> hardMute); // R2

  AST_LOAD_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rstPinN)
    loadDefaults |-> $past(mclkActive)); // R5

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstPinN)
    loadDefaults |=> !loadDefaults); // R6

  AST_RAMP_UNMUTES: assert property (@(posedge clk) disable iff (!rstPinN)
    rampStart |-> (!hardMute && !pwmForceLow && !volFullAtten)); // R9

  AST_RAMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstPinN)
    rampStart |=> !rampStart); // R9

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstPinN)
    $rose(seqReady) |-> $past(rampDone)); // R10
endmodule

bind bringup_seq bringup_seq_chk uChk (
  .clk(clk), .rstPinN(rstPinN), .rampDone(rampDone), .hardMute(hardMute),
  .pwmForceLow(pwmForceLow), .volFullAtten(volFullAtten), .accessBlock(accessBlock),
  .loadDefaults(loadDefaults), .rampStart(rampStart), .seqReady(seqReady),
  .mclkActive(mclkActive)
);

// File: tb/tb_bringup_seq.sv
module tb_bringup_seq;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WDOG = 8;
  localparam int EDGES = 20;

  logic clk = 1'b0;
  logic rstPinN, powerEn, mclkIn, rampDone, mclkOn;
  logic hardMute, pwmForceLow, volFullAtten, accessBlock;
  logic loadDefaults, rampStart, seqReady, mclkActive;

  int checks = 0;
  int fails = 0;
  int loadCnt, rampCnt, edgeRun, lastEdges;
  logic measuring, mclkPrevTb;

  bringup_seq #(.SYNC_STAGES(2), .WDOG_CYCLES(WDOG), .INIT_EDGES(EDGES)) dut (
    .clk(clk), .rstPinN(rstPinN), .powerEn(powerEn), .mclkIn(mclkIn),
    .rampDone(rampDone), .hardMute(hardMute), .pwmForceLow(pwmForceLow),
    .volFullAtten(volFullAtten), .accessBlock(accessBlock),
    .loadDefaults(loadDefaults), .rampStart(rampStart), .seqReady(seqReady),
    .mclkActive(mclkActive)
  );

  always #2 clk = ~clk;

  // master clock: period 16 ns, edges offset from the reference clock
  initial begin
    mclkIn = 1'b0;
    #1;
    forever begin
      #8;
      if (mclkOn) mclkIn = ~mclkIn;
    end
  end

  // pulse and edge monitor
  always @(negedge clk) begin
    if (loadDefaults) begin
      loadCnt   = loadCnt + 1;
      measuring = 1'b1;
      edgeRun   = 0;
    end else if (measuring && mclkIn && !mclkPrevTb) begin
      edgeRun = edgeRun + 1;
    end
    if (rampStart) begin
      rampCnt   = rampCnt + 1;
      measuring = 1'b0;
      lastEdges = edgeRun;
    end
    mclkPrevTb = mclkIn;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    loadCnt = 0; rampCnt = 0; edgeRun = 0; lastEdges = -1; measuring = 1'b0;
  endtask

  task automatic resetWith(input logic pe, input logic mOn, input logic rd);
    @(negedge clk);
    rstPinN = 1'b0;
    mclkOn  = 1'b0;
    mclkIn  = 1'b0;
    powerEn = pe;
    rampDone = rd;
    repeat (3) @(negedge clk);
    clearMon();
    mclkOn  = mOn;
    rstPinN = 1'b1;
  endtask

  // {powerEn, mclkOn, rampDone, hardMute, accessBlock, volFullAtten, seqReady, loaded}
  localparam logic [7:0] VEC [0:4] = '{
    8'b0101_1100,  // powerEn low: held in reset (R3)
    8'b1001_0100,  // no master clock: waits muted, no defaults (R5)
    8'b1100_0001,  // full init, ramp pending (R9)
    8'b1110_0011,  // ramp done: ready (R10)
    8'b1011_0100   // early rampDone ignored (R10)
  };

  initial begin
    rstPinN = 1'b1; powerEn = 1'b0; rampDone = 1'b0; mclkOn = 1'b0;
    mclkPrevTb = 1'b0;
    clearMon();
    #1 rstPinN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hardMute in reset", int'(hardMute), 1);
    chk("R1 pwmForceLow in reset", int'(pwmForceLow), 1);
    chk("R2 accessBlock in reset", int'(accessBlock), 1);
    chk("R1 seqReady in reset", int'(seqReady), 0);

    for (int i = 0; i < 5; i++) begin
      resetWith(VEC[i][7], VEC[i][6], VEC[i][5]);
      repeat (400) @(negedge clk);
      chk($sformatf("R3 row%0d hardMute", i), int'(hardMute), int'(VEC[i][4]));
      chk($sformatf("R2 row%0d accessBlock", i), int'(accessBlock), int'(VEC[i][3]));
      chk($sformatf("R9 row%0d volFullAtten", i), int'(volFullAtten), int'(VEC[i][2]));
      chk($sformatf("R10 row%0d seqReady", i), int'(seqReady), int'(VEC[i][1]));
      chk($sformatf("R5 row%0d loadDefaults count", i), loadCnt, int'(VEC[i][0]));
    end

    // R6 R7 R9: one bring-up, measured window
    resetWith(1'b1, 1'b1, 1'b0);
    repeat (300) @(negedge clk);
    chk("R6 single loadDefaults", loadCnt, 1);
    chk("R9 single rampStart", rampCnt, 1);
    chk("R7 window within one edge", int'(lastEdges >= EDGES - 1 && lastEdges <= EDGES + 1), 1);
    chk("R9 pwmForceLow released", int'(pwmForceLow), 0);

    // R11 and R4: master clock stops once ready
    rampDone = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 ready after rampDone", int'(seqReady), 1);
    mclkOn = 1'b0;
    @(negedge clk);
    chk("R4 still active just after stop", int'(mclkActive), 1);
    repeat (WDOG + 8) @(negedge clk);
    chk("R4 inactive after window", int'(mclkActive), 0);
    chk("R11 ready kept", int'(seqReady), 1);
    chk("R11 mute kept off", int'(hardMute), 0);
    chk("R11 atten kept off", int'(volFullAtten), 0);

    // R1: asynchronous entry between clock edges
    @(posedge clk);
    #0.5 rstPinN = 1'b0;
    #0.5;
    chk("R1 async hardMute", int'(hardMute), 1);
    chk("R1 async volFullAtten", int'(volFullAtten), 1);
    chk("R1 async pwmForceLow", int'(pwmForceLow), 1);
    chk("R2 async accessBlock", int'(accessBlock), 1);
    chk("R1 async seqReady", int'(seqReady), 0);

    // R8: clock lost during initialization
    resetWith(1'b1, 1'b1, 1'b0);
    while (loadCnt == 0) @(negedge clk);
    repeat (10) @(negedge clk);
    mclkOn = 1'b0;
    repeat (40) @(negedge clk);
    chk("R8 mute held after clock loss", int'(hardMute), 1);
    chk("R8 atten held after clock loss", int'(volFullAtten), 1);
    chk("R8 no rampStart", rampCnt, 0);
    chk("R4 inactive in wait", int'(mclkActive), 0);
    mclkOn = 1'b1;
    repeat (300) @(negedge clk);
    chk("R8 second loadDefaults", loadCnt, 2);
    chk("R8 ramp reached after restart", int'(hardMute), 0);
    chk("R6 one rampStart after restart", rampCnt, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule